// File: doc/BRIEF.md
# Dual-Processor Interrupt Hub

This block sits between a signal-processing core and a companion host microcontroller. It collects three interrupt sources for the signal-processing core and holds each one in a sticky pending bit. It then gates those bits through a per-source mask and a global enable, and picks the most urgent one with a fixed priority. It presents that choice as a registered interrupt line with a source number. Once the core acknowledges an interrupt, the block raises nothing more until the core signals the end of its service routine.

The block also provides two doorbells that cross between the processors. The host rings the core by setting a bit in its control-register write, and that doorbell feeds the top-priority source. The core rings the host through a registered interrupt line. On each side, a different bit of the other processor's control-register write clears the doorbell once it has been serviced.

Top module: `dsp_irq_hub`

## Requirements
- R1: A one-cycle pulse on `src_req[i]` sets pending bit i, and the bit stays set after the source drops. The bit is cleared only by a clear strobe or, for source 2, by the core's doorbell-clear bit.
- R2: Source numbers run 0, 1 and 2, and 2 is the most urgent. When several gated requests are pending, `dsp_vec` gives the highest source number among them.
- R3: After an accepted acknowledge, `dsp_irq` is low from the next cycle until the end of service, even for a more urgent request. It asserts again on the second clock edge after `rti` is sampled.
- R4: While the global enable is 0, `dsp_irq` stays low. Pending bits are kept and are signalled once the enable is written to 1.
- R5: A mask bit of 1 in `mask_d` lets its source through. A masked source does not take part in the priority selection.
- R6: `clr_strobe[i]` clears pending bit i. If a set and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R7: A host write with bit 1 of `host_wdata` at 1 sets pending bit 2. A host write with only bit 0 set does not.
- R8: A core write with bit 4 of `dsp_wdata` at 1 clears pending bit 2.
- R9: A core write with bit 9 of `dsp_wdata` at 1 raises `host_irq` at the next edge. A host write with bit 0 at 1 clears it. When both happen in the same cycle, `host_irq` stays high.
- R10: Reset clears all pending bits, the in-service state and both doorbells. It also sets the global enable and every mask bit to 0.
- R11: A request sampled at a clock edge shows on `dsp_irq` at the following edge. `ack` is ignored while `dsp_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 3 | Per-source request events |
| clr_strobe | input | 3 | Per-source pending clear |
| glb_en_we | input | 1 | Global enable write strobe |
| glb_en_d | input | 1 | Global enable write value |
| mask_we | input | 1 | Mask write strobe |
| mask_d | input | 3 | Mask write value, 1 = allowed |
| host_wr | input | 1 | Host control write strobe |
| host_wdata | input | 8 | Host control write data |
| dsp_wr | input | 1 | Core control write strobe |
| dsp_wdata | input | 16 | Core control write data |
| ack | input | 1 | Core accepts the presented interrupt |
| rti | input | 1 | Core ends its service routine |
| dsp_irq | output | 1 | Registered interrupt to the core |
| dsp_vec | output | 2 | Source number being presented |
| host_irq | output | 1 | Registered interrupt to the host |

## Verification
The priority path is swept across every combination of the three pending bits and the three mask bits. In each case the bench computes the expected line level and the top surviving source number. This sweep separates masking faults from priority-order faults and from an OR-of-requests that ignores the mask. Directed sequences then cover service in progress with a more urgent arrival, enable off with requests retained, and simultaneous set and clear on both the pending bits and the host doorbell. Together these tell the no-nesting rule apart from simple gating, and set-wins apart from clear-wins.

// File: rtl/dsp_irq_hub_pkg.sv
package dsp_irq_hub_pkg;
  localparam int SRC_N    = 3;
  localparam int HOST_W   = 8;
  localparam int DSP_W    = 16;
  // control-register bit positions decoded by the hub
  localparam int HOST_RING_BIT = 1;  // host rings the core
  localparam int HOST_CLR_BIT  = 0;  // host clears the core's doorbell
  localparam int DSP_RING_BIT  = 9;  // core rings the host
  localparam int DSP_CLR_BIT   = 4;  // core clears the host's doorbell

  typedef struct packed {
    logic ring_core;   // host -> core doorbell set
    logic clr_core;    // core clears host-originated request
    logic ring_host;   // core -> host doorbell set
    logic clr_host;    // host clears core-originated request
  } bell_cmd_t;
endpackage

// File: rtl/irq_ctl_decode.sv
module irq_ctl_decode
  import dsp_irq_hub_pkg::*;
#(
  parameter int HW = HOST_W,
  parameter int DW = DSP_W,
  parameter int H_RING = HOST_RING_BIT,
  parameter int H_CLR  = HOST_CLR_BIT,
  parameter int D_RING = DSP_RING_BIT,
  parameter int D_CLR  = DSP_CLR_BIT
) (
  input  logic          host_wr,
  input  logic [HW-1:0] host_wdata,
  input  logic          dsp_wr,
  input  logic [DW-1:0] dsp_wdata,
  output bell_cmd_t     cmd
);
  always_comb begin
    cmd.ring_core = host_wr & host_wdata[H_RING];
    cmd.clr_host  = host_wr & host_wdata[H_CLR];
    cmd.ring_host = dsp_wr  & dsp_wdata[D_RING];
    cmd.clr_core  = dsp_wr  & dsp_wdata[D_CLR];
  end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_v,
  input  logic [N-1:0] clr_v,
  output logic [N-1:0] pend_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            pend_q[i] <= 1'b0;
      else if (set_v[i])  pend_q[i] <= 1'b1;   // set wins over clear
      else if (clr_v[i])  pend_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  gated,
  input  logic          ack,
  input  logic          rti,
  output logic          irq_q,
  output logic [IW-1:0] vec_q,
  output logic          in_svc_q,
  output logic [IW-1:0] svc_id_q
);
  logic          any_req;
  logic [IW-1:0] top_id;
  logic          take;

  always_comb begin
    any_req = |gated;
    top_id  = '0;
    for (int i = 0; i < N; i++)
      if (gated[i]) top_id = IW'(i);   // later index overrides: highest wins
  end

  assign take = ack & irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_svc_q <= 1'b0;
      svc_id_q <= '0;
      irq_q    <= 1'b0;
      vec_q    <= '0;
    end else begin
      if (take) begin
        in_svc_q <= 1'b1;
        svc_id_q <= vec_q;
      end else if (rti) begin
        in_svc_q <= 1'b0;
      end
      irq_q <= any_req & ~in_svc_q & ~take;
      vec_q <= top_id;
    end
  end
endmodule

// File: rtl/dsp_irq_hub.sv
module dsp_irq_hub
  import dsp_irq_hub_pkg::*;
#(
  parameter int N  = SRC_N,
  parameter int HW = HOST_W,
  parameter int DW = DSP_W,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  src_req,
  input  logic [N-1:0]  clr_strobe,
  input  logic          glb_en_we,
  input  logic          glb_en_d,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_d,
  input  logic          host_wr,
  input  logic [HW-1:0] host_wdata,
  input  logic          dsp_wr,
  input  logic [DW-1:0] dsp_wdata,
  input  logic          ack,
  input  logic          rti,
  output logic          dsp_irq,
  output logic [IW-1:0] dsp_vec,
  output logic          host_irq
);
  bell_cmd_t     cmd;
  logic [N-1:0]  set_v, clr_v, pend_q, gated, mask_q;
  logic          glb_en_q, in_svc_q;
  logic [IW-1:0] svc_id_q;
  logic [0:0]    hdb_q;

  irq_ctl_decode #(.HW(HW), .DW(DW)) u_dec (
    .host_wr(host_wr), .host_wdata(host_wdata),
    .dsp_wr(dsp_wr), .dsp_wdata(dsp_wdata), .cmd(cmd)
  );

  // the host doorbell feeds the most urgent source
  always_comb begin
    set_v = src_req;
    clr_v = clr_strobe;
    set_v[N-1] = src_req[N-1] | cmd.ring_core;
    clr_v[N-1] = clr_strobe[N-1] | cmd.clr_core;
  end

  irq_pend_bank #(.N(N)) u_pend (
    .clk(clk), .rst(rst), .set_v(set_v), .clr_v(clr_v), .pend_q(pend_q)
  );

  irq_pend_bank #(.N(1)) u_hostbell (
    .clk(clk), .rst(rst), .set_v(cmd.ring_host), .clr_v(cmd.clr_host), .pend_q(hdb_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_en_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      if (glb_en_we) glb_en_q <= glb_en_d;
      if (mask_we)   mask_q   <= mask_d;
    end
  end

  assign gated = pend_q & mask_q & {N{glb_en_q}};

  irq_prio_sel #(.N(N)) u_sel (
    .clk(clk), .rst(rst), .gated(gated), .ack(ack), .rti(rti),
    .irq_q(dsp_irq), .vec_q(dsp_vec), .in_svc_q(in_svc_q), .svc_id_q(svc_id_q)
  );

  assign host_irq = hdb_q[0];
endmodule

// File: rtl/dsp_irq_hub_chk.sv
module dsp_irq_hub_chk #(
  parameter int N  = 3,
  parameter int IW = 2,
  parameter int HW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [N-1:0]  gated,
  input logic          glb_en_q,
  input logic          in_svc_q,
  input logic          ack,
  input logic          rti,
  input logic          dsp_irq,
  input logic [IW-1:0] dsp_vec,
  input logic          host_irq,
  input logic          host_wr,
  input logic [HW-1:0] host_wdata,
  input logic          dsp_wr,
  input logic [DW-1:0] dsp_wdata,
  input logic [N-1:0]  pend_q
);
  // R3
  no_nest_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && dsp_irq) |=> !dsp_irq);
  // R3
  svc_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    in_svc_q |-> !dsp_irq);
  // R4
  glb_off_chk: assert property (@(posedge clk) disable iff (rst)
    !glb_en_q |=> !dsp_irq);
  // R2
  top_first_chk: assert property (@(posedge clk) disable iff (rst)
    (gated[N-1] && !in_svc_q && !(ack && dsp_irq)) |=> (dsp_irq && dsp_vec == IW'(N-1)));
  // R9
  ring_host_chk: assert property (@(posedge clk) disable iff (rst)
    (dsp_wr && dsp_wdata[9]) |=> host_irq);
  // R7
  ring_core_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_wdata[1]) |=> pend_q[N-1]);
  // R2
  vec_range_chk: assert property (@(posedge clk) disable iff (rst)
    dsp_irq |-> (dsp_vec < IW'(N)));
endmodule

bind dsp_irq_hub dsp_irq_hub_chk #(.N(N), .IW(IW), .HW(HW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .gated(gated), .glb_en_q(glb_en_q), .in_svc_q(in_svc_q),
  .ack(ack), .rti(rti), .dsp_irq(dsp_irq), .dsp_vec(dsp_vec), .host_irq(host_irq),
  .host_wr(host_wr), .host_wdata(host_wdata), .dsp_wr(dsp_wr), .dsp_wdata(dsp_wdata),
  .pend_q(pend_q)
);

// File: tb/dsp_irq_hub_bench.sv
module dsp_irq_hub_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  src_req = '0, clr_strobe = '0, mask_d = '0;
  logic        glb_en_we = 0, glb_en_d = 0, mask_we = 0;
  logic        host_wr = 0, dsp_wr = 0, ack = 0, rti = 0;
  logic [7:0]  host_wdata = '0;
  logic [15:0] dsp_wdata = '0;
  logic        dsp_irq, host_irq;
  logic [1:0]  dsp_vec;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;   // 50 MHz

  dsp_irq_hub u_dsp_irq_hub (
    .clk(clk), .rst(rst), .src_req(src_req), .clr_strobe(clr_strobe),
    .glb_en_we(glb_en_we), .glb_en_d(glb_en_d), .mask_we(mask_we), .mask_d(mask_d),
    .host_wr(host_wr), .host_wdata(host_wdata), .dsp_wr(dsp_wr), .dsp_wdata(dsp_wdata),
    .ack(ack), .rti(rti), .dsp_irq(dsp_irq), .dsp_vec(dsp_vec), .host_irq(host_irq)
  );

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle;
    src_req = '0; clr_strobe = '0; glb_en_we = 0; mask_we = 0;
    host_wr = 0; dsp_wr = 0; ack = 0; rti = 0; host_wdata = '0; dsp_wdata = '0;
  endtask

  task automatic clear_all;
    clr_strobe = 3'b111; tick; idle; tick;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle;
    rst = 1; tick; tick; tick; rst = 0; tick;
    chk("R10 irq after reset", dsp_irq, 0);
    chk("R10 host_irq after reset", host_irq, 0);

    // enable and mask start off after reset
    src_req = 3'b111; tick; idle; tick; tick;
    chk("R10 enable/mask off", dsp_irq, 0);
    glb_en_we = 1; glb_en_d = 1; mask_we = 1; mask_d = 3'b111; tick; idle; tick;
    chk("R1 sticky after enable", dsp_irq, 1);
    chk("R1 sticky vec", dsp_vec, 2);
    clear_all;
    chk("R6 clear all", dsp_irq, 0);

    // R2 R5 sweep over pending x mask
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 8; p++) begin
        int g, top;
        mask_we = 1; mask_d = 3'(m); src_req = 3'(p); tick; idle; tick;
        g = p & m;
        top = (g & 4) ? 2 : (g & 2) ? 1 : 0;
        chk($sformatf("R5 irq p=%0d m=%0d", p, m), dsp_irq, (g != 0) ? 1 : 0);
        if (g != 0) chk($sformatf("R2 vec p=%0d m=%0d", p, m), dsp_vec, top);
        clear_all;
      end
    end
    mask_we = 1; mask_d = 3'b111; tick; idle;

    // R4 enable off keeps pending
    glb_en_we = 1; glb_en_d = 0; src_req = 3'b010; tick; idle; tick; tick;
    chk("R4 off blocks", dsp_irq, 0);
    glb_en_we = 1; glb_en_d = 1; tick; idle; tick;
    chk("R4 retained irq", dsp_irq, 1);
    chk("R4 retained vec", dsp_vec, 1);
    clear_all;

    // R3 no nesting
    src_req = 3'b001; tick; idle; tick;
    chk("R11 latency", dsp_irq, 1);
    chk("R2 vec low", dsp_vec, 0);
    ack = 1; tick; idle;
    chk("R3 drop on ack", dsp_irq, 0);
    src_req = 3'b100; tick; idle; tick; tick;
    chk("R3 higher blocked", dsp_irq, 0);
    rti = 1; tick; idle;
    chk("R3 not yet after rti", dsp_irq, 0);
    tick;
    chk("R3 resume after rti", dsp_irq, 1);
    chk("R3 resume vec", dsp_vec, 2);
    ack = 1; tick; idle; clr_strobe = 3'b101; tick; idle; rti = 1; tick; idle; tick; tick;
    chk("R6 cleared during service", dsp_irq, 0);

    // R11 ack ignored when idle
    ack = 1; tick; idle;
    src_req = 3'b001; tick; idle; tick;
    chk("R11 stray ack ignored", dsp_irq, 1);
    clear_all;

    // R6 set wins
    src_req = 3'b010; clr_strobe = 3'b010; tick; idle; tick;
    chk("R6 set wins", dsp_irq, 1);
    chk("R6 set wins vec", dsp_vec, 1);
    clear_all;

    // R7 R8 host doorbell into core
    host_wr = 1; host_wdata = 8'h01; tick; idle; tick;
    chk("R7 bit0 does not ring", dsp_irq, 0);
    host_wr = 1; host_wdata = 8'h02; tick; idle; tick;
    chk("R7 host ring", dsp_irq, 1);
    chk("R7 host ring vec", dsp_vec, 2);
    dsp_wr = 1; dsp_wdata = 16'h0010; tick; idle; tick;
    chk("R8 core clears", dsp_irq, 0);
    chk("R8 host_irq untouched", host_irq, 0);

    // R9 core doorbell into host
    dsp_wr = 1; dsp_wdata = 16'h0200; tick; idle;
    chk("R9 ring host", host_irq, 1);
    tick;
    chk("R9 holds", host_irq, 1);
    host_wr = 1; host_wdata = 8'h01; tick; idle;
    chk("R9 host clears", host_irq, 0);
    dsp_wr = 1; dsp_wdata = 16'h0200; host_wr = 1; host_wdata = 8'h01; tick; idle;
    chk("R9 set wins", host_irq, 1);
    host_wr = 1; host_wdata = 8'h01; tick; idle;
    chk("R9 cleared again", host_irq, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule